// File: doc/BRIEF.md
# Dual-path registered bus transceiver

This block moves data between two buses, A and B, in both directions. Each direction has its own storage register. A load strobe for that direction writes the register on the common clock. A select input picks what a driving side presents: the live value from the opposite side, or the stored word. Each side has its own output enable. The B-side enable is active-high and the A-side enable is active-low. Tri-state pins are split into an input vector, an output vector and a per-bit enable vector for each port.

The data width is cut into independent sections, each with its own six controls. The default build has two 9-bit sections, which can also be driven together as one 18-bit path. A register always captures the value actually present on its own side's pins. When that side is not driving, this is the input vector. When that side is driving, it is the block's own output. This lets a driven bus reload both registers from one source. If both sides are enabled and both are set to transparent, the block would form a loop through itself. In that case it turns both drivers off instead.

Top module: `dual_bus_xcvr`

## Requirements
- R1: Reset (rst_n low) clears both registers of every section at once. After rst_n rises, loads take effect only after two clock edges.
- R2: On a clock edge with ld_ab high, a section's A-to-B register takes the section's effective A value. With ld_ab low it holds its value.
- R3: On a clock edge with ld_ba high, a section's B-to-A register takes the section's effective B value. With ld_ba low it holds its value.
- R4: While B drives: sel_ab = 0 puts the live effective A value on b_out; sel_ab = 1 puts the stored A-to-B word on b_out.
- R5: While A drives: sel_ba = 0 puts the live effective B value on a_out; sel_ba = 1 puts the stored B-to-A word on a_out.
- R6: B drives when oe_b = 1, and A drives when oe_a_n = 0. A side that is not driving shows all-zero output and enable bits. A driving side shows enable bits of all ones.
- R7: Isolation (oe_b = 0, oe_a_n = 1) drives nothing. Loads still store a_in and b_in.
- R8: With A driven live from B (oe_b = 0, oe_a_n = 0, sel_ba = 0), loading both registers on one edge stores b_in in both.
- R9: With B driven live from A (oe_b = 1, oe_a_n = 1, sel_ab = 0), loading both registers on one edge stores a_in in both.
- R10: With both sides driving from storage, each side shows the other direction's stored word. Loading both on one edge swaps the two registers.
- R11: If both sides are enabled and both selects are 0, neither side drives. Each register then loads its own side's input vector.
- R12: Each section follows only its own controls. Data in one section never affects another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both storage directions |
| rst_n | input | 1 | Active-low reset: asserts at once, releases in step with the clock |
| a_in | input | 18 | Value read from the A pins |
| a_out | output | 18 | Value the block drives onto the A pins |
| a_oe | output | 18 | Per-bit drive enable for the A pins |
| b_in | input | 18 | Value read from the B pins |
| b_out | output | 18 | Value the block drives onto the B pins |
| b_oe | output | 18 | Per-bit drive enable for the B pins |
| ld_ab | input | 2 | Per section: load the A-to-B register |
| ld_ba | input | 2 | Per section: load the B-to-A register |
| sel_ab | input | 2 | Per section: B outputs show 0 live A, 1 stored A |
| sel_ba | input | 2 | Per section: A outputs show 0 live B, 1 stored B |
| oe_b | input | 2 | Per section: B-side output enable, active high |
| oe_a_n | input | 2 | Per section: A-side output enable, active low |

## Verification
The bench builds the block with its defaults: two sections of nine bits. With two sections it can give one section a drive mode while the other is isolated and loading, which is what makes the independence check of R12 possible. The 18-bit data patterns differ in every section. This means a swapped slice or a cross-section leak shows up in the compared words. A table of vectors walks the loopback, swap and conflict cases one after another, so each case starts from register contents that the previous rows left behind.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Per-section control bundle as seen at one clock edge.
  typedef struct packed {
    logic ld_ab;
    logic ld_ba;
    logic sel_ab;
    logic sel_ba;
    logic oe_b;
    logic oe_a_n;
  } sec_ctrl_t;

  localparam int unsigned RST_STAGES = 2;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  sec_ctrl_t    ctl,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] reg_ab,
  input  logic [W-1:0] reg_ba,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         a_drv,
  output logic         b_drv,
  output logic [W-1:0] a_eff,
  output logic [W-1:0] b_eff
);

  logic a_req, b_req, loop_hit;
  logic [W-1:0] b_seen, a_seen, a_val, b_val;

  always_comb begin
    a_req    = ~ctl.oe_a_n;
    b_req    = ctl.oe_b;
    // Both sides transparent and enabled would close a loop: drop both.
    loop_hit = a_req & b_req & ~ctl.sel_ab & ~ctl.sel_ba;
    a_drv    = a_req & ~loop_hit;
    b_drv    = b_req & ~loop_hit;

    // Pin values resolved without a combinational cycle.
    b_seen = b_drv ? (ctl.sel_ab ? reg_ab : a_in) : b_in;
    a_seen = a_drv ? (ctl.sel_ba ? reg_ba : b_in) : a_in;
    a_val  = ctl.sel_ba ? reg_ba : b_seen;
    b_val  = ctl.sel_ab ? reg_ab : a_seen;

    a_out  = a_drv ? a_val : '0;
    b_out  = b_drv ? b_val : '0;
    a_eff  = a_drv ? a_val : a_in;
    b_eff  = b_drv ? b_val : b_in;
  end

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_q,
  input  sec_ctrl_t    ctl,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  logic [W-1:0] reg_ab_q, reg_ab_d;
  logic [W-1:0] reg_ba_q, reg_ba_d;
  logic [W-1:0] a_eff, b_eff;
  logic         a_drv, b_drv;

  xcvr_route #(.W(W)) u_route (
    .ctl    (ctl),
    .a_in   (a_in),
    .b_in   (b_in),
    .reg_ab (reg_ab_q),
    .reg_ba (reg_ba_q),
    .a_out  (a_out),
    .b_out  (b_out),
    .a_drv  (a_drv),
    .b_drv  (b_drv),
    .a_eff  (a_eff),
    .b_eff  (b_eff)
  );

  // Next-state: clock enables written out.
  always_comb begin
    reg_ab_d = ctl.ld_ab ? a_eff : reg_ab_q;
    reg_ba_d = ctl.ld_ba ? b_eff : reg_ba_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      reg_ab_q <= '0;
      reg_ba_q <= '0;
    end else begin
      reg_ab_q <= reg_ab_d;
      reg_ba_q <= reg_ba_d;
    end
  end

  assign a_oe = {W{a_drv}};
  assign b_oe = {W{b_drv}};

  // R2: load captures the effective A value, otherwise holds.
  p_store_ab_r2: assert property (@(posedge clk) disable iff (!rst_q)
    ctl.ld_ab |=> reg_ab_q == $past(a_eff));
  p_hold_ab_r2: assert property (@(posedge clk) disable iff (!rst_q)
    !ctl.ld_ab |=> $stable(reg_ab_q));
  // R3: same for the B-to-A direction.
  p_store_ba_r3: assert property (@(posedge clk) disable iff (!rst_q)
    ctl.ld_ba |=> reg_ba_q == $past(b_eff));
  p_hold_ba_r3: assert property (@(posedge clk) disable iff (!rst_q)
    !ctl.ld_ba |=> $stable(reg_ba_q));
  // R6: drivers follow their enables with the right polarity.
  p_b_polarity_r6: assert property (@(posedge clk) disable iff (!rst_q)
    b_drv |-> ctl.oe_b);
  p_a_polarity_r6: assert property (@(posedge clk) disable iff (!rst_q)
    a_drv |-> !ctl.oe_a_n);
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !a_drv |-> a_out == '0);
  // R11: the transparent loop never drives either side.
  p_loop_off_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (ctl.oe_b && !ctl.oe_a_n && !ctl.sel_ab && !ctl.sel_ba) |-> (a_oe == '0 && b_oe == '0));
  // R10: both stored, both loaded -> contents exchange.
  p_swap_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (ctl.oe_b && !ctl.oe_a_n && ctl.sel_ab && ctl.sel_ba && ctl.ld_ab && ctl.ld_ba)
      |=> (reg_ab_q == $past(reg_ba_q) && reg_ba_q == $past(reg_ab_q)));

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned SEC_W = 9,
  parameter int unsigned NSEC  = 2,
  localparam int unsigned DW   = SEC_W * NSEC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   a_in,
  output logic [DW-1:0]   a_out,
  output logic [DW-1:0]   a_oe,
  input  logic [DW-1:0]   b_in,
  output logic [DW-1:0]   b_out,
  output logic [DW-1:0]   b_oe,
  input  logic [NSEC-1:0] ld_ab,
  input  logic [NSEC-1:0] ld_ba,
  input  logic [NSEC-1:0] sel_ab,
  input  logic [NSEC-1:0] sel_ba,
  input  logic [NSEC-1:0] oe_b,
  input  logic [NSEC-1:0] oe_a_n
);

  logic rst_q;

  xcvr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    sec_ctrl_t ctl;
    assign ctl = '{ld_ab: ld_ab[s], ld_ba: ld_ba[s], sel_ab: sel_ab[s],
                   sel_ba: sel_ba[s], oe_b: oe_b[s], oe_a_n: oe_a_n[s]};

    xcvr_section #(.W(SEC_W)) u_sec (
      .clk   (clk),
      .rst_q (rst_q),
      .ctl   (ctl),
      .a_in  (a_in [s*SEC_W +: SEC_W]),
      .b_in  (b_in [s*SEC_W +: SEC_W]),
      .a_out (a_out[s*SEC_W +: SEC_W]),
      .a_oe  (a_oe [s*SEC_W +: SEC_W]),
      .b_out (b_out[s*SEC_W +: SEC_W]),
      .b_oe  (b_oe [s*SEC_W +: SEC_W])
    );
  end

endmodule

// File: tb/sim_dual_bus_xcvr.sv
`timescale 1ns/100ps
module sim_dual_bus_xcvr;

  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] a_in, b_in, a_out, b_out, a_oe, b_oe;
  logic [1:0]    ld_ab, ld_ba, sel_ab, sel_ba, oe_b, oe_a_n;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dual_bus_xcvr u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ld_ab(ld_ab), .ld_ba(ld_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .oe_b(oe_b), .oe_a_n(oe_a_n)
  );

  typedef struct packed {
    logic ld_ab, ld_ba, sab, sba, oeb, oea_n;
    logic [17:0] a, b, ea, eb;
    logic eaoe, eboe;
  } vec_t;

  // Fields: ld_ab ld_ba sel_ab sel_ba oe_b oe_a_n | a_in b_in | exp a_out b_out | exp a_oe b_oe
  localparam vec_t VECS [14] = '{
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 18'h12345,18'h2ABCD, 18'h00000,18'h00000, 1'b0,1'b0}, // R7 isolation store
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 18'h3FFFF,18'h00001, 18'h2ABCD,18'h12345, 1'b1,1'b1}, // R10 R7 stored view
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 18'h3FFFF,18'h00001, 18'h2ABCD,18'h12345, 1'b1,1'b1}, // R10 swap edge
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 18'h00000,18'h00000, 18'h12345,18'h2ABCD, 1'b1,1'b1}, // R10 swapped
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 18'h0F0F0,18'h11111, 18'h00000,18'h0F0F0, 1'b0,1'b1}, // R4 R9 A live to B
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 18'h00000,18'h00000, 18'h0F0F0,18'h0F0F0, 1'b1,1'b1}, // R9 both hold A
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 18'h22222,18'h15A5A, 18'h15A5A,18'h00000, 1'b1,1'b0}, // R5 R8 B live to A
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 18'h00000,18'h00000, 18'h15A5A,18'h15A5A, 1'b1,1'b1}, // R8 both hold B
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 18'h03C3C,18'h30303, 18'h00000,18'h00000, 1'b0,1'b0}, // R11 loop off
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 18'h00000,18'h00000, 18'h15A5A,18'h03C3C, 1'b1,1'b1}, // R11 R2 R3 result
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 18'h00000,18'h2FFFF, 18'h00000,18'h03C3C, 1'b0,1'b1}, // R3 R6 B stores own drive
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 18'h00000,18'h00000, 18'h03C3C,18'h03C3C, 1'b1,1'b1}, // R3 result
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 18'h00000,18'h0AAAA, 18'h03C3C,18'h00000, 1'b1,1'b0}, // R2 R5 A stores own drive
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 18'h00000,18'h00000, 18'h0AAAA,18'h03C3C, 1'b1,1'b1}  // R2 R3 result
  };

  function automatic string row_tag(int i);
    case (i)
      0:        return "R7";
      1, 2, 3:  return "R10";
      4:        return "R4/R9";
      5:        return "R9";
      6:        return "R5/R8";
      7:        return "R8";
      8, 9:     return "R11";
      10, 11:   return "R3";
      default:  return "R2";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] lab, logic [1:0] lba, logic [1:0] sab, logic [1:0] sba,
                       logic [1:0] ob, logic [1:0] oan, logic [DW-1:0] a, logic [DW-1:0] b);
    ld_ab = lab; ld_ba = lba; sel_ab = sab; sel_ba = sba;
    oe_b = ob; oe_a_n = oan; a_in = a; b_in = b;
  endtask

  // Apply after a falling edge, then sample 1 ns before the rising edge.
  task automatic step(logic [1:0] lab, logic [1:0] lba, logic [1:0] sab, logic [1:0] sba,
                      logic [1:0] ob, logic [1:0] oan, logic [DW-1:0] a, logic [DW-1:0] b);
    @(negedge clk);
    drive(lab, lba, sab, sba, ob, oan, a, b);
    #1.5;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, '0, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: registers empty after reset, viewed through stored paths.
    step(2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 18'h3FFFF, 18'h3FFFF);
    chk("R1", "a_out", a_out, '0);
    chk("R1", "b_out", b_out, '0);
    chk("R6", "a_oe", a_oe, '1);
    chk("R6", "b_oe", b_oe, '1);

    for (int i = 0; i < 14; i++) begin
      vec_t v;
      v = VECS[i];
      step({2{v.ld_ab}}, {2{v.ld_ba}}, {2{v.sab}}, {2{v.sba}},
           {2{v.oeb}}, {2{v.oea_n}}, v.a, v.b);
      chk(row_tag(i), "a_out", a_out, v.ea);
      chk(row_tag(i), "b_out", b_out, v.eb);
      chk(row_tag(i), "a_oe", a_oe, {DW{v.eaoe}});
      chk(row_tag(i), "b_oe", b_oe, {DW{v.eboe}});
    end

    // R12: section 0 stored view, section 1 isolated and loading A.
    step(2'b10, 2'b00, 2'b01, 2'b01, 2'b01, 2'b10, 18'h3FFFF, 18'h00000);
    chk("R12", "a_out", a_out, 18'h000AA);
    chk("R12", "b_out", b_out, 18'h0003C);
    chk("R12", "a_oe", a_oe, 18'h001FF);
    chk("R12", "b_oe", b_oe, 18'h001FF);
    step(2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 18'h00000, 18'h00000);
    chk("R12", "b_out", b_out, 18'h3FE3C);
    chk("R12", "a_out", a_out, 18'h0AAAA);

    // R1: reset clears at once, loads during reset are lost.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "a_out async", a_out, '0);
    chk("R1", "b_out async", b_out, '0);
    step(2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 18'h155AA, 18'h2AA55);
    step(2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 18'h155AA, 18'h2AA55);
    @(negedge clk);
    rst_n = 1'b1;
    drive(2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 18'h155AA, 18'h2AA55);
    repeat (3) @(negedge clk);
    #1.5;
    chk("R1", "a_out after release", a_out, '0);
    chk("R1", "b_out after release", b_out, '0);

    // R2 R3: loads work again once reset has released.
    step(2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 18'h155AA, 18'h2AA55);
    step(2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 18'h00000, 18'h00000);
    chk("R2", "b_out", b_out, 18'h155AA);
    chk("R3", "a_out", a_out, 18'h2AA55);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule